// File: doc/BRIEF.md
# Four-Way Intersection Signal Sequencer

This block sequences the lamps at a crossing of two roads. It drives two light groups, east-west and north-south, and each group has separate red, yellow and green outputs. The controller runs a fixed loop of six phases. After each group's yellow there is a long clearance phase in which both groups show red, and only then does the other group get green.

Time is measured in ticks, not in clock cycles. A one-cycle enable strobe, `tick`, marks each tick. A phase holds for a programmed number of ticks. The hold for the green phases, the yellow phases and the clearance phases is set at build time by three separate parameters. A 3-bit phase index is output next to the lamps for monitoring. If the phase register ever holds one of the unused codes, the next clock edge forces it back to a both-red clearance phase.

Top module: `intersection_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to phase 0 with the hold count cleared: east-west green, north-south red, `phase` = 0.
- R2: Phases advance strictly in the order 0, 1, 2, 3, 4, 5, and phase 5 is followed by phase 0.
- R3: Phases 0 and 3 (the green phases) each last exactly GREEN_TICKS accepted ticks.
- R4: Phases 1 and 4 (the yellow phases) each last exactly AMBER_TICKS accepted ticks.
- R5: Phases 2 and 5 (the both-red clearance phases) each last exactly CLEAR_TICKS accepted ticks.
- R6: The lamps follow the phase. With lamps packed {ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green}, the patterns are: phase 0 = 001100, phase 1 = 010100, phase 2 = 100100, phase 3 = 100001, phase 4 = 100010, phase 5 = 100100. The lamps change on the same clock edge as `phase`.
- R7: A clock edge at which `tick` is low changes neither the phase, nor the lamps, nor the hold count.
- R8: Each direction has exactly one lamp lit in every cycle, and the two directions never show green or yellow at the same time.
- R9: A phase changes on the clock edge where `tick` is high and the hold count has reached that phase's duration minus one. A reset in the middle of the loop restarts phase 0 with its full hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-tick enable strobe |
| ew_red | output | 1 | East-west red lamp |
| ew_yellow | output | 1 | East-west yellow lamp |
| ew_green | output | 1 | East-west green lamp |
| ns_red | output | 1 | North-south red lamp |
| ns_yellow | output | 1 | North-south yellow lamp |
| ns_green | output | 1 | North-south green lamp |
| phase | output | 3 | Current phase index, 0 to 5 |

## Verification
The bench builds the block with GREEN_TICKS = 4, AMBER_TICKS = 2 and CLEAR_TICKS = 3 instead of the 120/5/60 defaults. With these values two full loops take only a few dozen ticks. Every phase boundary, the 5-to-0 wrap and the last-tick edge of each hold class can therefore be checked tick by tick. Because the three durations differ, a phase that uses the wrong hold parameter is exposed. The same is true when a clearance phase is dropped or two phases are swapped.

// File: rtl/isq_pkg.sv
// Package isq_pkg
// Holds the types and pure functions that the sequencer modules share.
// Assumes a six-phase loop encoded in three bits; codes 6 and 7 are unused.
package isq_pkg;

    typedef enum logic [2:0] {
        PH_EW_GO    = 3'd0,
        PH_EW_WARN  = 3'd1,
        PH_CLEAR_A  = 3'd2,
        PH_NS_GO    = 3'd3,
        PH_NS_WARN  = 3'd4,
        PH_CLEAR_B  = 3'd5
    } phase_e;

    localparam int unsigned NUM_PHASES = 6;

    // One light head: red, yellow, green.
    typedef struct packed {
        logic red;
        logic yellow;
        logic green;
    } head_t;

    typedef struct packed {
        head_t ew;
        head_t ns;
    } lamps_t;

    localparam head_t HEAD_RED    = '{red: 1'b1, yellow: 1'b0, green: 1'b0};
    localparam head_t HEAD_YELLOW = '{red: 1'b0, yellow: 1'b1, green: 1'b0};
    localparam head_t HEAD_GREEN  = '{red: 1'b0, yellow: 1'b0, green: 1'b1};

    // True when the code is one of the six real phases.
    function automatic logic phase_legal(input logic [2:0] code);
        return code < 3'(NUM_PHASES);
    endfunction

    // Successor in the fixed loop; unused codes fall back to a both-red phase.
    function automatic logic [2:0] phase_next(input logic [2:0] code);
        logic [2:0] nxt;
        case (code)
            3'd0:    nxt = 3'd1;
            3'd1:    nxt = 3'd2;
            3'd2:    nxt = 3'd3;
            3'd3:    nxt = 3'd4;
            3'd4:    nxt = 3'd5;
            3'd5:    nxt = 3'd0;
            default: nxt = 3'(PH_CLEAR_A);
        endcase
        return nxt;
    endfunction

    // Hold time in ticks for a phase, given the three class durations.
    function automatic int unsigned phase_ticks(input logic [2:0] code,
                                                input int unsigned green_t,
                                                input int unsigned amber_t,
                                                input int unsigned clear_t);
        int unsigned t;
        case (code)
            3'd0, 3'd3: t = green_t;
            3'd1, 3'd4: t = amber_t;
            3'd2, 3'd5: t = clear_t;
            default:    t = 1;
        endcase
        return t;
    endfunction

    // Lamp pattern shown during a phase; unused codes show red both ways.
    function automatic lamps_t phase_lamps(input logic [2:0] code);
        lamps_t l;
        case (code)
            3'd0:    begin l.ew = HEAD_GREEN;  l.ns = HEAD_RED;    end
            3'd1:    begin l.ew = HEAD_YELLOW; l.ns = HEAD_RED;    end
            3'd3:    begin l.ew = HEAD_RED;    l.ns = HEAD_GREEN;  end
            3'd4:    begin l.ew = HEAD_RED;    l.ns = HEAD_YELLOW; end
            default: begin l.ew = HEAD_RED;    l.ns = HEAD_RED;    end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/isq_hold_timer.sv
// Module isq_hold_timer
// Counts accepted ticks inside the current phase. It raises `expire` in the
// cycle where a tick arrives while the count equals `limit`; on that edge the
// count wraps to zero. Assumes `limit` is stable for the whole phase.
module isq_hold_timer #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    logic [CW-1:0] count_q;

    // Terminal detect: this tick is the last one of the phase.
    always_comb begin
        expire = tick && (count_q == limit);
    end

    // Tick counter with wrap on expiry and forced clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count_q <= '0;
        end else if (tick) begin
            if (expire) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/isq_phase_ctrl.sv
// Module isq_phase_ctrl
// Holds the phase register and steps it along the fixed loop when the hold
// timer expires. An unused code is replaced by a both-red phase on the next
// edge, whatever the tick. Also exports the next-state value so that other
// registers can be loaded in step with the phase.
module isq_phase_ctrl
    import isq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    output logic [2:0] phase_q,
    output logic [2:0] phase_d,
    output logic       illegal
);

    // Flag a phase code outside the loop.
    always_comb begin
        illegal = !phase_legal(phase_q);
    end

    // Next phase: recover, advance or hold.
    always_comb begin
        if (illegal) begin
            phase_d = 3'(PH_CLEAR_A);
        end else if (expire) begin
            phase_d = phase_next(phase_q);
        end else begin
            phase_d = phase_q;
        end
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 3'(PH_EW_GO);
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/isq_lamp_reg.sv
// Module isq_lamp_reg
// Registers the six lamp drives from the next phase value, so the lamps and
// the phase register change on the same edge and the lamp pins carry no
// decode logic. Assumes `phase_d` is the value the phase register loads.
module isq_lamp_reg
    import isq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] phase_d,
    output lamps_t     lamps_q
);

    // Lamp register loaded with the pattern of the upcoming phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lamps_q <= phase_lamps(3'(PH_EW_GO));
        end else begin
            lamps_q <= phase_lamps(phase_d);
        end
    end

endmodule

// File: rtl/intersection_sequencer.sv
// Module intersection_sequencer
// Six-phase signal sequencer for a two-road crossing. Each phase holds for a
// parameter-set number of ticks. Assumes `tick` is synchronous to `clk`. All
// outputs are registered.
module intersection_sequencer
    import isq_pkg::*;
#(
    parameter int unsigned GREEN_TICKS = 120,
    parameter int unsigned AMBER_TICKS = 5,
    parameter int unsigned CLEAR_TICKS = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic       ew_red,
    output logic       ew_yellow,
    output logic       ew_green,
    output logic       ns_red,
    output logic       ns_yellow,
    output logic       ns_green,
    output logic [2:0] phase
);

    localparam int unsigned MAX_A  = (GREEN_TICKS > AMBER_TICKS) ? GREEN_TICKS : AMBER_TICKS;
    localparam int unsigned MAX_T  = (MAX_A > CLEAR_TICKS) ? MAX_A : CLEAR_TICKS;
    localparam int unsigned CW     = (MAX_T > 1) ? $clog2(MAX_T) : 1;

    logic [2:0]    phase_q;
    logic [2:0]    phase_d;
    logic          illegal;
    logic          expire;
    logic [CW-1:0] limit;
    lamps_t        lamps_q;

    // Terminal count of the current phase (duration minus one).
    always_comb begin
        limit = CW'(phase_ticks(phase_q, GREEN_TICKS, AMBER_TICKS, CLEAR_TICKS) - 1);
    end

    isq_hold_timer #(
        .CW (CW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (illegal),
        .limit   (limit),
        .expire  (expire)
    );

    isq_phase_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .phase_q (phase_q),
        .phase_d (phase_d),
        .illegal (illegal)
    );

    isq_lamp_reg u_lamps (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_d (phase_d),
        .lamps_q (lamps_q)
    );

    // Map the registered lamp struct and phase onto the pins.
    always_comb begin
        ew_red    = lamps_q.ew.red;
        ew_yellow = lamps_q.ew.yellow;
        ew_green  = lamps_q.ew.green;
        ns_red    = lamps_q.ns.red;
        ns_yellow = lamps_q.ns.yellow;
        ns_green  = lamps_q.ns.green;
        phase     = phase_q;
    end

endmodule

// File: rtl/isq_checker.sv
// Module isq_checker
// Property checker bound to intersection_sequencer. It watches only the ports
// and keeps its own tick count to check hold durations.
module isq_checker
    import isq_pkg::*;
#(
    parameter int unsigned GREEN_TICKS = 120,
    parameter int unsigned AMBER_TICKS = 5,
    parameter int unsigned CLEAR_TICKS = 60
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       ew_red,
    input logic       ew_yellow,
    input logic       ew_green,
    input logic       ns_red,
    input logic       ns_yellow,
    input logic       ns_green,
    input logic [2:0] phase
);

    int unsigned seen;
    int unsigned hold_len;

    always_comb begin
        hold_len = phase_ticks(phase, GREEN_TICKS, AMBER_TICKS, CLEAR_TICKS);
    end

    // Independent count of ticks accepted in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 0;
        end else if (tick) begin
            seen <= (seen + 1 >= hold_len) ? 0 : seen + 1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (phase == 3'd0 && ew_green && ns_red));

    a_r2_loop_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && phase != $past(phase)) |-> (phase == phase_next($past(phase))));

    // R3 R4 R5: phase ends on the tick that completes its hold.
    a_r5_hold_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen + 1 == hold_len) |=> (phase != $past(phase)));

    // R3 R4 R5: no early exit.
    a_r9_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen + 1 < hold_len) |=> $stable(phase));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(phase) && $stable({ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green})));

    a_r8_one_lamp_ew: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ew_red, ew_yellow, ew_green}) == 1);

    a_r8_one_lamp_ns: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ns_red, ns_yellow, ns_green}) == 1);

    a_r8_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        !((ew_green || ew_yellow) && (ns_green || ns_yellow)));

    a_r6_ew_go_lamps: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0) |-> (ew_green && ns_red));

    a_r6_ns_go_lamps: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) |-> (ns_green && ew_red));

    a_r6_warn_lamps: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 || phase == 3'd4) |-> (ew_yellow != ns_yellow));

    a_r6_clear_lamps: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 || phase == 3'd5) |-> (ew_red && ns_red));

endmodule

bind intersection_sequencer isq_checker #(
    .GREEN_TICKS (GREEN_TICKS),
    .AMBER_TICKS (AMBER_TICKS),
    .CLEAR_TICKS (CLEAR_TICKS)
) u_isq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ew_red    (ew_red),
    .ew_yellow (ew_yellow),
    .ew_green  (ew_green),
    .ns_red    (ns_red),
    .ns_yellow (ns_yellow),
    .ns_green  (ns_green),
    .phase     (phase)
);

// File: tb/intersection_sequencer_tb.sv
// Bench for intersection_sequencer with short hold times.
module intersection_sequencer_tb;

    localparam int unsigned G = 4;
    localparam int unsigned A = 2;
    localparam int unsigned C = 3;

    // Each entry: {phase[2:0], lamps[5:0], ticks[7:0]}; lamps = {ew r,y,g, ns r,y,g}.
    localparam logic [16:0] VEC [0:5] = '{
        {3'd0, 6'b001100, 8'(G)},
        {3'd1, 6'b010100, 8'(A)},
        {3'd2, 6'b100100, 8'(C)},
        {3'd3, 6'b100001, 8'(G)},
        {3'd4, 6'b100010, 8'(A)},
        {3'd5, 6'b100100, 8'(C)}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green;
    logic [2:0] phase;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    intersection_sequencer #(
        .GREEN_TICKS (G),
        .AMBER_TICKS (A),
        .CLEAR_TICKS (C)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ew_red    (ew_red),
        .ew_yellow (ew_yellow),
        .ew_green  (ew_green),
        .ns_red    (ns_red),
        .ns_yellow (ns_yellow),
        .ns_green  (ns_green),
        .phase     (phase)
    );

    function automatic logic [5:0] lamps();
        return {ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green};
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // R8: one lamp per head and no conflicting go/warn.
    task automatic check_safe();
        logic ok;
        ok = ($countones({ew_red, ew_yellow, ew_green}) == 1) &&
             ($countones({ns_red, ns_yellow, ns_green}) == 1) &&
             !((ew_green || ew_yellow) && (ns_green || ns_yellow));
        check("R8 lamp exclusivity", {8'd0, ok}, 9'd1);
    endtask

    // One tick pulse; outputs sampled at the following falling edge.
    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset phase/lamps", {phase, lamps()}, {3'd0, 6'b001100});
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk over two full loops.
        for (int lap = 0; lap < 2; lap++) begin
            for (int i = 0; i < 6; i++) begin
                int dur;
                int nxt;
                dur = int'(VEC[i][7:0]);
                nxt = (i + 1) % 6;
                check("R6 lamps on phase entry", {phase, lamps()}, VEC[i][16:8]);
                check_safe();
                pulse(dur - 1);
                check("R3 R4 R5 phase held until last tick", {6'd0, phase}, {6'd0, VEC[i][16:14]});
                pulse(1);
                check("R2 R9 advance on last tick", {6'd0, phase}, {6'd0, VEC[nxt][16:14]});
            end
        end

        // R7: idle cycles with tick low change nothing, then the count resumes.
        pulse(1);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            check("R7 idle hold", {phase, lamps()}, {3'd0, 6'b001100});
        end
        pulse(G - 2);
        check("R7 count preserved across idle", {6'd0, phase}, 9'd0);
        pulse(1);
        check("R7 expiry after idle gap", {phase, lamps()}, {3'd1, 6'b010100});

        // R3: tick held high continuously, advance after exactly G edges.
        pulse(A + C);
        check("R5 reached north-south green", {phase, lamps()}, {3'd3, 6'b100001});
        tick = 1'b1;
        repeat (G - 1) @(negedge clk);
        check("R3 continuous ticks, still green", {6'd0, phase}, 9'd3);
        @(negedge clk);
        tick = 1'b0;
        check("R3 continuous ticks, advanced", {phase, lamps()}, {3'd4, 6'b100010});
        check_safe();

        // R9: reset mid-loop restarts phase 0 with the full hold.
        pulse(1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid-loop reset", {phase, lamps()}, {3'd0, 6'b001100});
        pulse(G - 1);
        check("R9 full hold after reset", {6'd0, phase}, 9'd0);
        pulse(1);
        check("R9 first advance after reset", {6'd0, phase}, 9'd1);

        // R1: reset with tick high still wins.
        tick = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset overrides tick", {phase, lamps()}, {3'd0, 6'b001100});
        tick = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule